// File: doc/BRIEF.md
# Sixteen-Pin GPIO Port with Pull-Up Resolution and Change Notification

The block is a general-purpose I/O port seen by software through a small register interface. A single wide control word sets, for every pin, whether the processor drives it and whether its pull-up is on. A data register holds the value the processor drives. A peripheral on the other side supplies its own enable and value vectors. The block works out the level each pin actually shows from the two drivers and the pull-ups. Reading the data register returns those resolved levels, not the stored data.

The resolved lines are tracked each cycle against a registered copy from the cycle before. A change may come from a register write or from the peripheral inputs. When the lines change, the XOR of old and new is presented as a change vector. Each of up to four client slots holds a trigger mask and a valid bit. A slot gets a one-cycle notification strobe when it is valid and its mask overlaps the change. Port interrupts are not generated. Writing a nonzero value to the interrupt-control register raises an unsupported-configuration flag instead.

Top module: `gpio_port`

## Requirements
- R1: In the 32-bit control word (address 0), bit 2n enables the processor drive of pin n and bit 2n+1 enables the pull-up of pin n. A read of address 0 returns the word as written.
- R2: Each pin equals (cpu_dir & cpu_data) | (periph_oe & periph_val) | (~(cpu_dir | periph_oe) & pullup), bit by bit. When both sides drive a pin, the result is the OR of the two values. A pin with no driver and no pull-up reads 0.
- R3: A read of the data register (address 1) returns the resolved pins in bits 15:0, not the value last written.
- R4: change_o shows, one cycle late, the XOR of the resolved lines with their value one cycle earlier. When the lines do not move, change_o is 0 and no strobe fires.
- R5: notify_o[i] pulses for exactly one cycle, in the cycle after the edge at which the lines changed, when slot i is valid and (mask_i & change) is nonzero.
- R6: A slot whose valid bit is clear is never notified, even when its mask overlaps the change.
- R7: Changes caused only by the peripheral inputs are detected and notified by the same rule.
- R8: A write to address 2 with bits 15:0 nonzero sets cfg_unsup_o. A write of zero clears it. Reading address 2 returns the flag in bit 0.
- R9: Reset clears the control word, the data register, all masks, all valid bits and the flag. With the peripheral idle, all pins read 0 and no strobe is active.
- R10: Data writes keep only wdata[15:0]. Slot i sits at address 4+i, with the mask in bits 15:0 and the valid bit at bit 16. Slot reads return that layout.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_valid | input | 1 | Register access strobe |
| reg_write | input | 1 | 1 = write, 0 = read |
| reg_addr | input | 3 | Register address |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, combinational, during a valid read |
| periph_oe | input | 16 | Peripheral drive enables |
| periph_val | input | 16 | Peripheral drive values |
| pins_o | output | 16 | Resolved pin levels |
| change_o | output | 16 | Registered change vector |
| notify_o | output | 4 | Per-slot notification strobes |
| cfg_unsup_o | output | 1 | Unsupported interrupt configuration flag |

## Verification
The bench runs these corner cases:
- Pins driven by both sides at once. A design that muxed the drivers instead of ORing them would lose the peripheral's high bits.
- Pull-ups on pins that are driven low. A design that let a pull-up win over a driver would show a 1 there.
- A control write that moves no line. This catches a design that fires strobes on every write rather than on real change.
- An invalid slot whose mask covers everything. This catches designs that ignore the valid bit.
- A change caused only by the peripheral, and the cycle after a strobe. These expose change detection tied only to the bus, and strobes that stretch past one cycle.

// File: rtl/gpio_pkg.sv
package gpio_pkg;
    localparam int ADDR_W    = 3;
    localparam int RD_W      = 32;
    localparam int SLOT_BASE = 4;

    typedef enum logic [ADDR_W-1:0] {
        REG_CTRL = 3'd0,
        REG_DATA = 3'd1,
        REG_IRQC = 3'd2
    } reg_sel_e;
endpackage

// File: rtl/gpio_cfg_split.sv
module gpio_cfg_split #(
    parameter int NPINS = 16
) (
    input  logic [2*NPINS-1:0] ctrl_i,
    output logic [NPINS-1:0]   dir_o,
    output logic [NPINS-1:0]   pull_o
);
    for (genvar n = 0; n < NPINS; n++) begin : g_pin
        assign dir_o[n]  = ctrl_i[2*n];
        assign pull_o[n] = ctrl_i[2*n+1];
    end
endmodule

// File: rtl/gpio_line_resolve.sv
module gpio_line_resolve #(
    parameter int NPINS = 16
) (
    input  logic [NPINS-1:0] cpu_dir_i,
    input  logic [NPINS-1:0] cpu_val_i,
    input  logic [NPINS-1:0] per_oe_i,
    input  logic [NPINS-1:0] per_val_i,
    input  logic [NPINS-1:0] pull_i,
    output logic [NPINS-1:0] lines_o
);
    logic [NPINS-1:0] undriven;

    always_comb begin
        undriven = ~(cpu_dir_i | per_oe_i);
        lines_o  = (cpu_dir_i & cpu_val_i) | (per_oe_i & per_val_i) | (undriven & pull_i);
    end
endmodule

// File: rtl/gpio_change_notify.sv
module gpio_change_notify #(
    parameter int NPINS    = 16,
    parameter int NCLIENTS = 4
) (
    input  logic                            clk,
    input  logic                            rst_n,
    input  logic [NPINS-1:0]                lines_i,
    input  logic [NCLIENTS-1:0][NPINS-1:0]  masks_i,
    input  logic [NCLIENTS-1:0]             valid_i,
    output logic [NPINS-1:0]                change_o,
    output logic [NCLIENTS-1:0]             notify_o
);
    typedef struct packed {
        logic [NPINS-1:0]    prev;
        logic [NPINS-1:0]    change;
        logic [NCLIENTS-1:0] notify;
    } trk_t;

    trk_t trk_d, trk_q;

    always_comb begin
        trk_d.prev   = lines_i;
        trk_d.change = lines_i ^ trk_q.prev;
        for (int i = 0; i < NCLIENTS; i++) begin
            trk_d.notify[i] = valid_i[i] & (|(masks_i[i] & trk_d.change));
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) trk_q <= '0;
        else        trk_q <= trk_d;
    end

    assign change_o = trk_q.change;
    assign notify_o = trk_q.notify;
endmodule

// File: rtl/gpio_port.sv
module gpio_port
    import gpio_pkg::*;
#(
    parameter int NPINS    = 16,
    parameter int NCLIENTS = 4
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                reg_valid,
    input  logic                reg_write,
    input  logic [ADDR_W-1:0]   reg_addr,
    input  logic [RD_W-1:0]     reg_wdata,
    output logic [RD_W-1:0]     reg_rdata,
    input  logic [NPINS-1:0]    periph_oe,
    input  logic [NPINS-1:0]    periph_val,
    output logic [NPINS-1:0]    pins_o,
    output logic [NPINS-1:0]    change_o,
    output logic [NCLIENTS-1:0] notify_o,
    output logic                cfg_unsup_o
);
    localparam int CTRL_W  = 2 * NPINS;
    localparam int VLD_BIT = NPINS;

    typedef struct packed {
        logic [CTRL_W-1:0]               ctrl;
        logic [NPINS-1:0]                data;
        logic [NCLIENTS-1:0][NPINS-1:0]  mask;
        logic [NCLIENTS-1:0]             valid;
        logic                            unsup;
    } regs_t;

    regs_t rg_d, rg_q;
    logic [NPINS-1:0] cpu_dir, cpu_pull;
    logic wr_en, rd_en;

    assign wr_en = reg_valid & reg_write;
    assign rd_en = reg_valid & ~reg_write;

    always_comb begin
        rg_d = rg_q;
        if (wr_en) begin
            case (reg_addr)
                REG_CTRL: rg_d.ctrl  = reg_wdata[CTRL_W-1:0];
                REG_DATA: rg_d.data  = reg_wdata[NPINS-1:0];
                REG_IRQC: rg_d.unsup = |reg_wdata[NPINS-1:0];
                default: ;
            endcase
            for (int i = 0; i < NCLIENTS; i++) begin
                if (int'(reg_addr) == SLOT_BASE + i) begin
                    rg_d.mask[i]  = reg_wdata[NPINS-1:0];
                    rg_d.valid[i] = reg_wdata[VLD_BIT];
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) rg_q <= '0;
        else        rg_q <= rg_d;
    end

    gpio_cfg_split #(.NPINS(NPINS)) u_split (
        .ctrl_i (rg_q.ctrl),
        .dir_o  (cpu_dir),
        .pull_o (cpu_pull)
    );

    gpio_line_resolve #(.NPINS(NPINS)) u_resolve (
        .cpu_dir_i (cpu_dir),
        .cpu_val_i (rg_q.data),
        .per_oe_i  (periph_oe),
        .per_val_i (periph_val),
        .pull_i    (cpu_pull),
        .lines_o   (pins_o)
    );

    gpio_change_notify #(.NPINS(NPINS), .NCLIENTS(NCLIENTS)) u_notify (
        .clk      (clk),
        .rst_n    (rst_n),
        .lines_i  (pins_o),
        .masks_i  (rg_q.mask),
        .valid_i  (rg_q.valid),
        .change_o (change_o),
        .notify_o (notify_o)
    );

    always_comb begin
        reg_rdata = '0;
        if (rd_en) begin
            case (reg_addr)
                REG_CTRL: reg_rdata = RD_W'(rg_q.ctrl);
                REG_DATA: reg_rdata = RD_W'(pins_o);
                REG_IRQC: reg_rdata = RD_W'(rg_q.unsup);
                default: ;
            endcase
            for (int i = 0; i < NCLIENTS; i++) begin
                if (int'(reg_addr) == SLOT_BASE + i) begin
                    reg_rdata = RD_W'({rg_q.valid[i], rg_q.mask[i]});
                end
            end
        end
    end

    assign cfg_unsup_o = rg_q.unsup;
endmodule

// File: rtl/gpio_port_chk.sv
module gpio_port_chk #(
    parameter int NPINS    = 16,
    parameter int NCLIENTS = 4
) (
    input logic                clk,
    input logic                rst_n,
    input logic                reg_valid,
    input logic                reg_write,
    input logic [2:0]          reg_addr,
    input logic [31:0]         reg_wdata,
    input logic [31:0]         reg_rdata,
    input logic [NPINS-1:0]    periph_oe,
    input logic [NPINS-1:0]    periph_val,
    input logic [NPINS-1:0]    pins_o,
    input logic [NPINS-1:0]    change_o,
    input logic [NCLIENTS-1:0] notify_o,
    input logic                cfg_unsup_o,
    input logic [NPINS-1:0]    cpu_dir,
    input logic [NPINS-1:0]    cpu_pull,
    input logic [NCLIENTS-1:0] slot_valid
);
    logic [1:0] age_q;
    always_ff @(posedge clk) begin
        if (!rst_n)            age_q <= '0;
        else if (age_q != 2'd3) age_q <= age_q + 2'd1;
    end

    // R2
    float_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((~(cpu_dir | periph_oe) & ~cpu_pull & pins_o) == '0));

    // R2
    pull_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((~(cpu_dir | periph_oe) & cpu_pull & ~pins_o) == '0));

    // R2
    periph_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((periph_oe & periph_val & ~pins_o) == '0));

    // R3
    data_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_valid && !reg_write && reg_addr == 3'd1) |-> (reg_rdata[NPINS-1:0] == pins_o));

    // R4
    change_track_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (age_q == 2'd3) |-> (change_o == ($past(pins_o, 2) ^ $past(pins_o))));

    // R5
    notify_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (|notify_o) |-> (change_o != '0));

    // R8
    unsup_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_valid && reg_write && reg_addr == 3'd2 && reg_wdata[NPINS-1:0] != '0) |=> cfg_unsup_o);

    for (genvar i = 0; i < NCLIENTS; i++) begin : g_slot
        // R6
        slot_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
            notify_o[i] |-> $past(slot_valid[i]));
    end
endmodule

bind gpio_port gpio_port_chk #(.NPINS(NPINS), .NCLIENTS(NCLIENTS)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .reg_valid   (reg_valid),
    .reg_write   (reg_write),
    .reg_addr    (reg_addr),
    .reg_wdata   (reg_wdata),
    .reg_rdata   (reg_rdata),
    .periph_oe   (periph_oe),
    .periph_val  (periph_val),
    .pins_o      (pins_o),
    .change_o    (change_o),
    .notify_o    (notify_o),
    .cfg_unsup_o (cfg_unsup_o),
    .cpu_dir     (cpu_dir),
    .cpu_pull    (cpu_pull),
    .slot_valid  (rg_q.valid)
);

// File: tb/gpio_port_bench.sv
module gpio_port_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_valid = 1'b0;
    logic        reg_write = 1'b0;
    logic [2:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic [15:0] periph_oe = '0;
    logic [15:0] periph_val = '0;
    logic [15:0] pins_o;
    logic [15:0] change_o;
    logic [3:0]  notify_o;
    logic        cfg_unsup_o;

    int errors = 0;
    int checks = 0;

    always #5 clk = ~clk;

    gpio_port u_gpio_port (
        .clk(clk), .rst_n(rst_n), .reg_valid(reg_valid), .reg_write(reg_write),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .periph_oe(periph_oe), .periph_val(periph_val), .pins_o(pins_o),
        .change_o(change_o), .notify_o(notify_o), .cfg_unsup_o(cfg_unsup_o)
    );

    // columns: control word, data write, periph_oe, periph_val
    localparam int NV = 6;
    localparam logic [95:0] VEC [NV] = '{
        {32'h0000_0000, 32'h0000_0000, 16'h0000, 16'h0000},
        {32'hAAAA_AAAA, 32'h0000_0000, 16'h0000, 16'h0000},
        {32'h5555_5555, 32'hABCD_1234, 16'h0000, 16'h0000},
        {32'hAAAA_AAAA, 32'h0000_0000, 16'h00FF, 16'h000F},
        {32'h0000_5555, 32'h0000_00A5, 16'hF000, 16'h3000},
        {32'hFFFF_FFFF, 32'h0000_0000, 16'h0F0F, 16'h0101}
    };

    function automatic logic [15:0] model(logic [31:0] c, logic [15:0] d,
                                          logic [15:0] oe, logic [15:0] v);
        logic [15:0] r = '0;
        for (int n = 0; n < 16; n++) begin
            if (c[2*n] || oe[n]) r[n] = (c[2*n] & d[n]) | (oe[n] & v[n]);
            else                 r[n] = c[2*n+1];
        end
        return r;
    endfunction

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(logic [2:0] a, logic [31:0] d);
        @(negedge clk);
        reg_valid = 1'b1; reg_write = 1'b1; reg_addr = a; reg_wdata = d;
        @(posedge clk);
        #1 reg_valid = 1'b0; reg_write = 1'b0;
    endtask

    task automatic rd(logic [2:0] a, output logic [31:0] d);
        @(negedge clk);
        reg_valid = 1'b1; reg_write = 1'b0; reg_addr = a;
        #1 d = reg_rdata;
        reg_valid = 1'b0;
    endtask

    task automatic next_cycle();
        @(posedge clk);
        @(negedge clk);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual=hung expected=finished");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        logic [31:0] rv;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R9 reset state
        @(negedge clk);
        check("R9 pins", 32'(pins_o), 32'h0);
        check("R9 notify", 32'(notify_o), 32'h0);
        rd(3'd0, rv); check("R9 ctrl", rv, 32'h0);
        rd(3'd4, rv); check("R9 slot0", rv, 32'h0);

        // R1 R2 R3 R10 vector table
        for (int k = 0; k < NV; k++) begin
            logic [31:0] c = VEC[k][95:64];
            logic [31:0] d = VEC[k][63:32];
            @(negedge clk);
            periph_oe = VEC[k][31:16]; periph_val = VEC[k][15:0];
            wr(3'd0, c);
            wr(3'd1, d);
            @(negedge clk);
            check("R2 pins", 32'(pins_o), 32'(model(c, d[15:0], VEC[k][31:16], VEC[k][15:0])));
            rd(3'd1, rv);
            check("R3 R10 data read", rv, 32'(model(c, d[15:0], VEC[k][31:16], VEC[k][15:0])));
            rd(3'd0, rv);
            check("R1 ctrl read", rv, c);
        end

        // quiet state before notification tests
        @(negedge clk); periph_oe = '0; periph_val = '0;
        wr(3'd0, 32'h0); wr(3'd1, 32'h0);
        next_cycle(); next_cycle();

        wr(3'd4, 32'h0001_0001);
        wr(3'd5, 32'h0001_0002);
        wr(3'd6, 32'h0000_FFFF);
        wr(3'd7, 32'h0001_8000);
        rd(3'd6, rv); check("R10 slot2 read", rv, 32'h0000_FFFF);
        rd(3'd7, rv); check("R10 slot3 read", rv, 32'h0001_8000);

        // R4 write that moves no line
        wr(3'd0, 32'h0000_0005);
        next_cycle();
        check("R4 no change", 32'(change_o), 32'h0);
        check("R4 no notify", 32'(notify_o), 32'h0);

        // R5 data write toggles pin 0
        wr(3'd1, 32'h0000_0001);
        next_cycle();
        check("R5 change", 32'(change_o), 32'h0001);
        check("R5 notify slot0", 32'(notify_o), 32'h1);
        next_cycle();
        check("R5 single pulse", 32'(notify_o), 32'h0);

        wr(3'd1, 32'h0000_0003);
        next_cycle();
        check("R5 notify slot1", 32'(notify_o), 32'h2);

        // R7 peripheral only
        @(negedge clk); periph_oe = 16'h8000; periph_val = 16'h8000;
        next_cycle();
        check("R7 change", 32'(change_o), 32'h8000);
        check("R7 notify slot3", 32'(notify_o), 32'h8);

        // R6 invalid slot with full mask; pull-up on pin 4
        wr(3'd0, 32'h0000_0205);
        next_cycle();
        check("R6 change", 32'(change_o), 32'h0010);
        check("R6 invalid slot silent", 32'(notify_o), 32'h0);

        // R8 unsupported flag
        wr(3'd2, 32'h0000_0001);
        @(negedge clk);
        check("R8 set", 32'(cfg_unsup_o), 32'h1);
        rd(3'd2, rv); check("R8 read", rv, 32'h1);
        wr(3'd2, 32'h0);
        @(negedge clk);
        check("R8 clear", 32'(cfg_unsup_o), 32'h0);
        wr(3'd2, 32'h0000_0100);

        // R9 reset mid-run
        @(negedge clk); periph_oe = '0; periph_val = '0; rst_n = 1'b0;
        next_cycle(); next_cycle();
        rst_n = 1'b1;
        @(negedge clk);
        check("R9 pins after reset", 32'(pins_o), 32'h0);
        check("R9 flag after reset", 32'(cfg_unsup_o), 32'h0);
        rd(3'd7, rv); check("R9 slot3 cleared", rv, 32'h0);
        rd(3'd0, rv); check("R9 ctrl cleared", rv, 32'h0);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule